// File: doc/BRIEF.md
# Dual-Link Redundant Frame Transmitter

Once per acquisition window this block takes a snapshot of a card's measurement data: the per-channel pulse counts, the per-channel integrator ADC samples, a 32-bit status word and a fixed card identity. From the snapshot it builds one frame of 16-bit words. The same frame is offered on two link ports at the same moment. Each port has a valid/ready word handshake and a level input that says whether its serializer can take traffic.

Each port works through the frame at its own pace and computes its own CRC-32. A fault in one link path therefore never alters what the other link carries. A 16-bit frame number goes up on every window tick, including ticks that send no frame. A receiver can use the card identity to catch a mis-cabled card and the frame number to spot lost frames.

The window tick comes from the measurement timebase. The link ports feed the serializer front-ends.

Top module: `dual_link_framer`

## Requirements
- R1: A frame is 23 words, sent in this order:
  - word 0 is the constant header 16'hC3A5;
  - word 1 is `card_id`;
  - word 2 is the frame number;
  - words 3..10 are channels 0..7 of `ch_count`;
  - words 11..18 are channels 0..7 of `ch_adc`;
  - word 19 is `status_word[31:16]` and word 20 is `status_word[15:0]`;
  - words 21 and 22 are the CRC, high half first.
  - Channel i of a packed input occupies bits [16*i+15:16*i].
- R2: The frame number is a 16-bit counter. It is 0 for the first tick after reset, goes up by one on every `frame_tick` cycle, and wraps from 16'hFFFF to 16'h0000.
- R3: The CRC is CRC-32 over words 0..20, each word fed most significant bit first. The polynomial is 0x04C11DB7, the register starts at 0xFFFFFFFF, there is no reflection, and there is no final inversion.
- R4: Both links carry identical word sequences. Each link advances only on its own `tx_ready`, so stalling one link does not delay the other.
- R5: A link whose `link_up` is low on the tick cycle sends nothing for that window. The other link sends normally, and the frame number still advances.
- R6: A tick that arrives while any link is still sending starts no frame on any link. The frame number still advances, so the next frame sent shows a gap of two.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. `tx_last` is high only with `tx_valid`, and only on word 22. `tx_valid` falls in the cycle after the last word is accepted.
- R8: After reset, `tx_valid` and `tx_last` are low on both links.
- R9: All payload inputs are captured in the tick cycle. Later changes to them do not alter the frame being sent.
- R10: When a frame starts, `tx_valid` rises in the cycle after the tick, with the header word on `tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse that opens an acquisition window |
| card_id | input | 16 | Fixed identity of this card |
| ch_count | input | 128 | Packed channel counts, channel i at bits 16*i and up |
| ch_adc | input | 128 | Packed integrator ADC samples, same packing |
| status_word | input | 32 | Card status flags |
| link_up | input | 2 | Per-link serializer available |
| tx_ready | input | 2 | Per-link word accept |
| tx_valid | output | 2 | Per-link word valid |
| tx_last | output | 2 | Per-link final word of frame |
| tx_data | output | 32 | Per-link word, link l at bits 16*l and up |

## Verification
A corrupted CRC register or word index in one port shows up only on that link. It appears as a mismatched CRC pair or a misplaced `tx_last` at the end of that link's very next frame, while the other link stays correct. That is why every frame is checked on both links separately and the two links are compared with each other. A wrong frame-number counter appears in word 2 of the next frame sent. The drop, busy and wrap cases are therefore arranged so that a skipped or doubled increment changes a visible value within one or two frames. A snapshot that is not held shows as payload words that follow input changes made after the tick.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
   localparam int unsigned CRC_W = 32;
   localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
   localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

   typedef enum logic {
      LP_IDLE = 1'b0,
      LP_SEND = 1'b1
   } lp_state_e;
endpackage

// File: rtl/dlf_crc_step.sv
module dlf_crc_step #(
   parameter int unsigned WORD_W = 16
) (
   input  logic [dlf_pkg::CRC_W-1:0] crc_in,
   input  logic [WORD_W-1:0]         din,
   output logic [dlf_pkg::CRC_W-1:0] crc_out
);
   always_comb begin
      logic [dlf_pkg::CRC_W-1:0] acc;
      acc = crc_in;
      for (int b = WORD_W - 1; b >= 0; b--) begin
         if (acc[dlf_pkg::CRC_W-1] ^ din[b]) begin
            acc = {acc[dlf_pkg::CRC_W-2:0], 1'b0} ^ dlf_pkg::CRC_POLY;
         end else begin
            acc = {acc[dlf_pkg::CRC_W-2:0], 1'b0};
         end
      end
      crc_out = acc;
   end
endmodule

// File: rtl/dlf_frame_snap.sv
module dlf_frame_snap #(
   parameter int unsigned  WORD_W    = 16,
   parameter int unsigned  NUM_CH    = 8,
   parameter int unsigned  STAT_W    = 32,
   parameter logic [15:0]  HDR_WORD  = 16'hC3A5,
   localparam int unsigned STAT_WORDS = STAT_W / WORD_W,
   localparam int unsigned PAY_WORDS  = 3 + 2 * NUM_CH + STAT_WORDS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick,
   input  logic                        capture,
   input  logic [WORD_W-1:0]           card_id,
   input  logic [NUM_CH*WORD_W-1:0]    ch_count,
   input  logic [NUM_CH*WORD_W-1:0]    ch_adc,
   input  logic [STAT_W-1:0]           status_word,
   output logic [PAY_WORDS*WORD_W-1:0] frame_words
);
   localparam int unsigned CNT_BASE  = 3;
   localparam int unsigned ADC_BASE  = CNT_BASE + NUM_CH;
   localparam int unsigned STAT_BASE = ADC_BASE + NUM_CH;

   logic [WORD_W-1:0]        fid_q;
   logic [WORD_W-1:0]        snap_fid_q;
   logic [WORD_W-1:0]        snap_card_q;
   logic [NUM_CH*WORD_W-1:0] snap_cnt_q;
   logic [NUM_CH*WORD_W-1:0] snap_adc_q;
   logic [STAT_W-1:0]        snap_stat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fid_q <= '0;
      end else if (tick) begin
         fid_q <= fid_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_fid_q  <= '0;
         snap_card_q <= '0;
         snap_cnt_q  <= '0;
         snap_adc_q  <= '0;
         snap_stat_q <= '0;
      end else if (capture) begin
         snap_fid_q  <= fid_q;
         snap_card_q <= card_id;
         snap_cnt_q  <= ch_count;
         snap_adc_q  <= ch_adc;
         snap_stat_q <= status_word;
      end
   end

   assign frame_words[0*WORD_W +: WORD_W] = WORD_W'(HDR_WORD);
   assign frame_words[1*WORD_W +: WORD_W] = snap_card_q;
   assign frame_words[2*WORD_W +: WORD_W] = snap_fid_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign frame_words[(CNT_BASE + c)*WORD_W +: WORD_W] = snap_cnt_q[c*WORD_W +: WORD_W];
      assign frame_words[(ADC_BASE + c)*WORD_W +: WORD_W] = snap_adc_q[c*WORD_W +: WORD_W];
   end

   for (genvar s = 0; s < STAT_WORDS; s++) begin : g_stat
      assign frame_words[(STAT_BASE + s)*WORD_W +: WORD_W] =
         snap_stat_q[STAT_W - 1 - s*WORD_W -: WORD_W];
   end
endmodule

// File: rtl/dlf_link_port.sv
module dlf_link_port #(
   parameter int unsigned  WORD_W    = 16,
   parameter int unsigned  PAY_WORDS = 21,
   localparam int unsigned CRC_WORDS = dlf_pkg::CRC_W / WORD_W,
   localparam int unsigned FRM_WORDS = PAY_WORDS + CRC_WORDS,
   localparam int unsigned IDX_W     = $clog2(FRM_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [PAY_WORDS*WORD_W-1:0] frame_words,
   input  logic                        ready,
   output logic                        valid,
   output logic                        last,
   output logic [WORD_W-1:0]           data,
   output logic                        busy
);
   import dlf_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRM_WORDS - 1);

   lp_state_e              st_q;
   logic [IDX_W-1:0]       idx_q;
   logic [CRC_W-1:0]       crc_q;
   logic [CRC_W-1:0]       crc_nxt;
   logic                   in_payload;
   logic                   fire;

   dlf_crc_step #(.WORD_W(WORD_W)) u_step (
      .crc_in (crc_q),
      .din    (data),
      .crc_out(crc_nxt)
   );

   assign in_payload = (idx_q < IDX_W'(PAY_WORDS));
   assign fire       = valid & ready;

   always_comb begin
      data = '0;
      for (int i = 0; i < PAY_WORDS; i++) begin
         if (idx_q == IDX_W'(i)) data = frame_words[i*WORD_W +: WORD_W];
      end
      for (int k = 0; k < CRC_WORDS; k++) begin
         if (idx_q == IDX_W'(PAY_WORDS + k)) data = crc_q[CRC_W - 1 - k*WORD_W -: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= LP_IDLE;
         idx_q <= '0;
         crc_q <= CRC_SEED;
      end else begin
         case (st_q)
            LP_IDLE: begin
               if (start) begin
                  st_q  <= LP_SEND;
                  idx_q <= '0;
                  crc_q <= CRC_SEED;
               end
            end
            default: begin
               if (fire) begin
                  if (in_payload) crc_q <= crc_nxt;
                  if (idx_q == LAST_IDX) begin
                     st_q  <= LP_IDLE;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign busy  = (st_q == LP_SEND);
   assign valid = busy;
   assign last  = busy & (idx_q == LAST_IDX);
endmodule

// File: rtl/dual_link_framer.sv
module dual_link_framer #(
   parameter int unsigned  NUM_LINKS = 2,
   parameter int unsigned  WORD_W    = 16,
   parameter int unsigned  NUM_CH    = 8,
   parameter logic [15:0]  HDR_WORD  = 16'hC3A5,
   localparam int unsigned STAT_W    = 32,
   localparam int unsigned PAY_WORDS = 3 + 2 * NUM_CH + STAT_W / WORD_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        frame_tick,
   input  logic [WORD_W-1:0]           card_id,
   input  logic [NUM_CH*WORD_W-1:0]    ch_count,
   input  logic [NUM_CH*WORD_W-1:0]    ch_adc,
   input  logic [STAT_W-1:0]           status_word,
   input  logic [NUM_LINKS-1:0]        link_up,
   input  logic [NUM_LINKS-1:0]        tx_ready,
   output logic [NUM_LINKS-1:0]        tx_valid,
   output logic [NUM_LINKS-1:0]        tx_last,
   output logic [NUM_LINKS*WORD_W-1:0] tx_data
);
   if (NUM_LINKS < 1) begin : g_bad_links
      $error("dual_link_framer: NUM_LINKS must be at least 1");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("dual_link_framer: NUM_CH must be at least 1");
   end
   if (WORD_W < 8 || WORD_W > 32 || (32 % WORD_W) != 0) begin : g_bad_word
      $error("dual_link_framer: WORD_W must divide 32 and be at least 8");
   end

   logic [NUM_LINKS-1:0]        port_busy;
   logic                        any_busy;
   logic                        accept;
   logic [PAY_WORDS*WORD_W-1:0] frame_words;

   assign any_busy = |port_busy;
   assign accept   = frame_tick & ~any_busy;

   dlf_frame_snap #(
      .WORD_W  (WORD_W),
      .NUM_CH  (NUM_CH),
      .STAT_W  (STAT_W),
      .HDR_WORD(HDR_WORD)
   ) u_snap (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (frame_tick),
      .capture    (accept),
      .card_id    (card_id),
      .ch_count   (ch_count),
      .ch_adc     (ch_adc),
      .status_word(status_word),
      .frame_words(frame_words)
   );

   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
      dlf_link_port #(
         .WORD_W   (WORD_W),
         .PAY_WORDS(PAY_WORDS)
      ) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (accept & link_up[l]),
         .frame_words(frame_words),
         .ready      (tx_ready[l]),
         .valid      (tx_valid[l]),
         .last       (tx_last[l]),
         .data       (tx_data[l*WORD_W +: WORD_W]),
         .busy       (port_busy[l])
      );
   end
endmodule

// File: rtl/dual_link_framer_chk.sv
module dual_link_framer_chk #(
   parameter int unsigned NUM_LINKS = 2,
   parameter int unsigned WORD_W    = 16,
   parameter logic [15:0] HDR_WORD  = 16'hC3A5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        frame_tick,
   input logic [NUM_LINKS-1:0]        link_up,
   input logic [NUM_LINKS-1:0]        tx_ready,
   input logic [NUM_LINKS-1:0]        tx_valid,
   input logic [NUM_LINKS-1:0]        tx_last,
   input logic [NUM_LINKS*WORD_W-1:0] tx_data
);
   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_chk
      // R7
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_valid[l] && !tx_ready[l]) |=> (tx_valid[l] && $stable(tx_data[l*WORD_W +: WORD_W])));

      // R7
      last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tx_last[l] |-> tx_valid[l]);

      // R7
      frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_valid[l] && tx_ready[l] && tx_last[l]) |=> !tx_valid[l]);

      // R5
      link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (frame_tick && !link_up[l] && !tx_valid[l]) |=> !tx_valid[l]);

      // R6
      busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (frame_tick && (|tx_valid) && !tx_valid[l]) |=> !tx_valid[l]);

      // R10
      start_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (frame_tick && link_up[l] && !(|tx_valid))
         |=> (tx_valid[l] && tx_data[l*WORD_W +: WORD_W] == WORD_W'(HDR_WORD)));
   end
endmodule

bind dual_link_framer dual_link_framer_chk #(
   .NUM_LINKS(NUM_LINKS),
   .WORD_W   (WORD_W),
   .HDR_WORD (HDR_WORD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_tick(frame_tick),
   .link_up   (link_up),
   .tx_ready  (tx_ready),
   .tx_valid  (tx_valid),
   .tx_last   (tx_last),
   .tx_data   (tx_data)
);

// File: tb/dual_link_framer_tb.sv
module dual_link_framer_tb;
   localparam int NL  = 2;
   localparam int W   = 16;
   localparam int NCH = 8;
   localparam int FW  = 23;
   localparam logic [15:0] HDR = 16'hC3A5;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n;
   logic               frame_tick;
   logic [W-1:0]       card_id;
   logic [NCH*W-1:0]   ch_count;
   logic [NCH*W-1:0]   ch_adc;
   logic [31:0]        status_word;
   logic [NL-1:0]      link_up;
   logic [NL-1:0]      tx_ready;
   logic [NL-1:0]      tx_valid;
   logic [NL-1:0]      tx_last;
   logic [NL*W-1:0]    tx_data;

   logic [15:0] cnt_v [NCH];
   logic [15:0] adc_v [NCH];

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         ch_count[i*W +: W] = cnt_v[i];
         ch_adc[i*W +: W]   = adc_v[i];
      end
   end

   dual_link_framer u_dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .card_id(card_id),
      .ch_count(ch_count), .ch_adc(ch_adc), .status_word(status_word),
      .link_up(link_up), .tx_ready(tx_ready), .tx_valid(tx_valid),
      .tx_last(tx_last), .tx_data(tx_data)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int proto_err = 0;
   int mode [NL];
   int rx_n [NL];
   int done [NL];
   logic [15:0] rx_w [NL][32];
   logic [15:0] got  [NL][FW];
   logic        stall_prev [NL];
   logic [15:0] data_prev  [NL];
   logic [15:0] exp_w [FW];
   logic [15:0] exp_fid;

   // receiver model: set ready for the coming edge, then record what that edge accepts
   always @(negedge clk) begin
      cyc++;
      for (int l = 0; l < NL; l++) begin
         logic [15:0] d;
         d = tx_data[l*W +: W];
         if (stall_prev[l] && (!tx_valid[l] || d != data_prev[l])) proto_err++;
         if (tx_last[l] && !tx_valid[l]) proto_err++;
         case (mode[l])
            0: tx_ready[l] = 1'b1;
            1: tx_ready[l] = (cyc % 2) == 0;
            2: tx_ready[l] = 1'b0;
            default: tx_ready[l] = (cyc % 3) != 0;
         endcase
         if (tx_valid[l] && tx_ready[l]) begin
            if (rx_n[l] < 32) rx_w[l][rx_n[l]] = d;
            if (tx_last[l]) begin
               if (rx_n[l] != FW - 1) proto_err++;
               for (int i = 0; i < FW; i++) got[l][i] = rx_w[l][i];
               done[l]++;
               rx_n[l] = 0;
            end else begin
               rx_n[l]++;
            end
         end else if (!tx_valid[l] && rx_n[l] != 0) begin
            proto_err++;
            rx_n[l] = 0;
         end
         stall_prev[l] = tx_valid[l] && !tx_ready[l];
         data_prev[l]  = d;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [15:0] w);
      logic [31:0] r;
      r = c;
      for (int b = 15; b >= 0; b--) begin
         logic fb;
         fb = r[31] ^ w[b];
         r = {r[30:0], 1'b0};
         if (fb) r = r ^ 32'h04C1_1DB7;
      end
      return r;
   endfunction

   task automatic build_exp(input logic [15:0] fid);
      logic [31:0] c;
      exp_w[0] = HDR;
      exp_w[1] = card_id;
      exp_w[2] = fid;
      for (int i = 0; i < NCH; i++) begin
         exp_w[3 + i]  = cnt_v[i];
         exp_w[11 + i] = adc_v[i];
      end
      exp_w[19] = status_word[31:16];
      exp_w[20] = status_word[15:0];
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 21; i++) c = crc_ref(c, exp_w[i]);
      exp_w[21] = c[31:16];
      exp_w[22] = c[15:0];
   endtask

   task automatic set_payload(input logic [15:0] seed);
      card_id = 16'h5A00 ^ seed;
      for (int i = 0; i < NCH; i++) begin
         cnt_v[i] = seed * 16'd7 + 16'(i * 257);
         adc_v[i] = ~seed + 16'(i * 4099);
      end
      status_word = {seed, ~seed} ^ 32'h1357_9BDF;
   endtask

   task automatic tick_once();
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
      exp_fid = exp_fid + 16'd1;
   endtask

   task automatic wait_done(input int l, input int target);
      int t = 0;
      while (done[l] < target && t < 3000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic check_frame(input int l, input string tag);
      int bad_p = -1;
      int bad_c = -1;
      for (int i = 0; i < FW; i++) begin
         if (i == 21 || i == 22) begin
            if (got[l][i] !== exp_w[i] && bad_c < 0) bad_c = i;
         end else if (i != 2) begin
            if (got[l][i] !== exp_w[i] && bad_p < 0) bad_p = i;
         end
      end
      chk(bad_p < 0, tag, $sformatf("link%0d payload word %0d", l, bad_p),
          bad_p < 0 ? 32'h0 : {16'h0, got[l][bad_p]}, bad_p < 0 ? 32'h0 : {16'h0, exp_w[bad_p]});
      chk(got[l][2] === exp_w[2], "R2", $sformatf("link%0d frame number", l),
          {16'h0, got[l][2]}, {16'h0, exp_w[2]});
      chk(bad_c < 0, "R3", $sformatf("link%0d crc", l),
          {got[l][21], got[l][22]}, {exp_w[21], exp_w[22]});
   endtask

   task automatic t_reset();
      @(negedge clk);
      // R8
      chk(tx_valid == '0 && tx_last == '0, "R8", "outputs idle after reset",
          {28'h0, tx_valid, tx_last}, 32'h0);
   endtask

   task automatic t_basic();
      int d0 = done[0];
      int d1 = done[1];
      mode[0] = 0; mode[1] = 0;
      set_payload(16'h0011);
      build_exp(exp_fid);
      tick_once();
      // R10
      chk(tx_valid == 2'b11 && tx_data == {HDR, HDR}, "R10", "header one cycle after tick",
          {14'h0, tx_valid, tx_data[15:0]}, {14'h0, 2'b11, HDR});
      wait_done(0, d0 + 1);
      wait_done(1, d1 + 1);
      check_frame(0, "R1");
      check_frame(1, "R1");
      begin
         bit same = 1'b1;
         for (int i = 0; i < FW; i++) if (got[0][i] !== got[1][i]) same = 1'b0;
         // R4
         chk(same, "R4", "links carry identical frames", {16'h0, got[0][21]}, {16'h0, got[1][21]});
      end
   endtask

   task automatic t_snapshot_stall();
      int d0 = done[0];
      int d1 = done[1];
      mode[0] = 1; mode[1] = 3;
      set_payload(16'hBEEF);
      build_exp(exp_fid);
      tick_once();
      set_payload(16'h0F0F);
      wait_done(0, d0 + 1);
      wait_done(1, d1 + 1);
      // R9
      check_frame(0, "R9");
      check_frame(1, "R9");
      mode[0] = 0; mode[1] = 0;
   endtask

   task automatic t_link_down();
      int d0 = done[0];
      int d1 = done[1];
      link_up = 2'b01;
      set_payload(16'h7777);
      build_exp(exp_fid);
      tick_once();
      wait_done(0, d0 + 1);
      repeat (40) @(negedge clk);
      // R5
      chk(done[1] == d1 && tx_valid[1] == 1'b0, "R5", "link1 silent while down",
          32'(done[1] - d1), 32'h0);
      check_frame(0, "R5");
      link_up = 2'b11;
   endtask

   task automatic t_busy();
      int d0 = done[0];
      int d1 = done[1];
      mode[0] = 2; mode[1] = 0;
      set_payload(16'h4242);
      build_exp(exp_fid);
      tick_once();
      wait_done(1, d1 + 1);
      repeat (5) @(negedge clk);
      tick_once();
      // R6
      chk(tx_valid == 2'b01, "R6", "no start while link0 busy", {30'h0, tx_valid}, 32'h1);
      mode[0] = 0;
      wait_done(0, d0 + 1);
      repeat (40) @(negedge clk);
      check_frame(0, "R6");
      chk(done[0] == d0 + 1 && done[1] == d1 + 1, "R6", "one frame per link only",
          32'(done[0] + done[1] - d0 - d1), 32'h2);
      set_payload(16'h9191);
      build_exp(exp_fid);
      tick_once();
      wait_done(0, d0 + 2);
      wait_done(1, d1 + 2);
      check_frame(0, "R6");
      check_frame(1, "R6");
   endtask

   task automatic t_wrap();
      int n;
      int d0 = done[0];
      link_up = 2'b00;
      n = 32'hFFFF - int'(exp_fid);
      @(negedge clk); frame_tick = 1'b1;
      repeat (n) @(negedge clk);
      frame_tick = 1'b0;
      exp_fid = 16'hFFFF;
      link_up = 2'b11;
      set_payload(16'h00AA);
      build_exp(exp_fid);
      tick_once();
      wait_done(0, d0 + 1);
      // R2
      check_frame(0, "R2");
      repeat (3) @(negedge clk);
      set_payload(16'h00BB);
      build_exp(exp_fid);
      tick_once();
      wait_done(0, d0 + 2);
      chk(got[0][2] == 16'h0000, "R2", "frame number wraps to zero", {16'h0, got[0][2]}, 32'h0);
      check_frame(0, "R2");
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin
         mode[l] = 0; rx_n[l] = 0; done[l] = 0; stall_prev[l] = 1'b0; data_prev[l] = '0;
      end
      tx_ready = '1;
      rst_n = 1'b0;
      frame_tick = 1'b0;
      link_up = 2'b11;
      exp_fid = 16'h0000;
      set_payload(16'h0000);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_snapshot_stall();
      t_link_down();
      t_busy();
      t_wrap();
      repeat (5) @(negedge clk);
      // R7
      chk(proto_err == 0, "R7", "handshake hold and last placement", 32'(proto_err), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule